// File: doc/BRIEF.md
# Masked Alarm and Interrupt Controller

This block watches the running time of a real-time clock and raises an alarm when the current seconds, minutes, hours and date agree with a set of programmed alarm registers. Four mask bits, one carried in the top bit of each alarm register, choose how many of those fields take part in the comparison. The rate can range from every second up to once a month on a given date. The comparison is made only when the one-second tick arrives, after the clock fields have settled. A match latches an alarm flag.

The flag drives an active-low open-drain pin, modelled here as a pull-low enable. It does so only when the alarm-enable bit is set. While the system runs from its backup supply, the alarm-in-backup enable bit must also be set. Any read or write at the flags address releases the pin for the length of the access and clears the flag when the access ends. The pin is shared with a watchdog interrupt, which comes in from outside, and with a frequency-test mode. In that mode the pin toggles on every 512 Hz enable pulse.

Register addresses are 0h for the flags, 2h through 5h for the seconds, minutes, hours and date alarms, and 6h for the control register. Each rise of the power-good input clears the enable bits and the frequency-test bit. Bus writes and flag clears are ignored while power-good is low.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the pin is released, and reads of the flags register (0h) and the control register (6h) return 00h.
- R2: The mask nibble is {date[7], hour[7], min[7], sec[7]} of the alarm registers. 1111 matches on every tick. 1110 compares seconds. 1100 compares seconds and minutes. 1000 compares seconds, minutes and hours. 0000 compares all four fields. Seconds and minutes compare bits 6:0; hours and date compare bits 5:0.
- R3: Every mask nibble outside those five values matches on every tick.
- R4: A match is evaluated only on a cycle where sec_tick is high; it then sets the alarm flag, which reads as bit 7 of register 0h.
- R5: With power good, the pin is pulled low while the flag is set and the alarm-enable bit (bit 7 of 6h) is 1; when that bit is 0 a set flag leaves the pin released.
- R6: With power-good low, the alarm pulls the pin low only when the alarm-in-backup bit (bit 6 of 6h) is also 1.
- R7: A read or write at 0h releases the alarm's pull on the pin during that access. The flag clears at the clock edge that ends the access. A tick match in the same cycle keeps the flag set.
- R8: A rise of power-good clears the alarm-enable, alarm-in-backup and frequency-test bits. A flag set while power-good is low is kept.
- R9: While power-good is low, bus writes and flag-register accesses change no state.
- R10: When osc_run is 1, the frequency-test bit (bit 0 of 6h) is 1, the alarm-enable bit is 0, and either wds or wdog_zero is 1, the pin toggles on each ft_tick pulse, starting from released. Otherwise the frequency-test path releases the pin.
- R11: A high wdog_irq pulls the pin low at once, regardless of the alarm state.
- R12: Registers 2h to 5h read back all 8 written bits. Register 6h reads AE at bit 7, ABE at bit 6 and FT at bit 0, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | 1 on main supply, 0 in backup |
| osc_run | input | 1 | Oscillator running |
| sec_tick | input | 1 | One-cycle pulse after the time fields update |
| ft_tick | input | 1 | One-cycle 512 Hz toggle enable |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current date, BCD |
| wds | input | 1 | Watchdog steering bit |
| wdog_zero | input | 1 | Watchdog register holds 00h |
| wdog_irq | input | 1 | Watchdog interrupt request |
| bus_sel | input | 1 | Register select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_pull | output | 1 | 1 pulls the open-drain pin low |

## Verification
The comparator is driven with random alarm values and random masks across all sixteen nibbles. Each time field is made equal to its alarm field in about half of the trials. This separates a correct choice of fields from one that compares too many or too few, and it shows whether an unlisted nibble falls back to every-tick matching. Directed cases cover a date-only mismatch under masks 0000 and 1000, and a time match presented without a tick. They also cover a flags read that coincides with a matching tick. Separate sequences through backup and power-up show whether the enable bits gate the pin, whether they are cleared on power-up, and whether bus writes are blocked. The frequency-test and watchdog paths are run under both enabling and disabling conditions.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          osc_run,
  input  logic          sec_tick,
  input  logic          ft_tick,
  input  logic [6:0]    cur_sec,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [5:0]    cur_date,
  input  logic          wds,
  input  logic          wdog_zero,
  input  logic          wdog_irq,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq_pull
);
  localparam logic [AW-1:0] A_FLAGS = AW'(0);
  localparam logic [AW-1:0] A_SEC   = AW'(2);
  localparam logic [AW-1:0] A_MIN   = AW'(3);
  localparam logic [AW-1:0] A_HOUR  = AW'(4);
  localparam logic [AW-1:0] A_DATE  = AW'(5);
  localparam logic [AW-1:0] A_CTRL  = AW'(6);

  logic [7:0] a_sec, a_min, a_hour, a_date;
  logic ae, abe, ft, af, pwr_q, ft_phase, hit;

  wire access   = bus_sel & (bus_rd | bus_wr) & pwr_ok;
  wire wr_en    = bus_sel & bus_wr & pwr_ok;
  wire flag_acc = access & (bus_addr == A_FLAGS);
  wire pwr_up   = pwr_ok & ~pwr_q;
  wire ft_en    = osc_run & ft & ~ae & (wds | wdog_zero);
  wire alarm_on = af & ae & (pwr_ok | abe);

  wire [3:0] mask = {a_date[7], a_hour[7], a_min[7], a_sec[7]};
  wire m_s = (cur_sec  == a_sec[6:0]);
  wire m_m = (cur_min  == a_min[6:0]);
  wire m_h = (cur_hour == a_hour[5:0]);
  wire m_d = (cur_date == a_date[5:0]);

  always_comb begin
    case (mask)
      4'b1110: hit = m_s;
      4'b1100: hit = m_s & m_m;
      4'b1000: hit = m_s & m_m & m_h;
      4'b0000: hit = m_s & m_m & m_h & m_d;
      default: hit = 1'b1;
    endcase
  end

  assign irq_pull = (alarm_on & ~flag_acc) | wdog_irq | (ft_en & ft_phase);

  always_comb begin
    case (bus_addr)
      A_FLAGS: bus_rdata = {af, 7'b0};
      A_SEC:   bus_rdata = a_sec;
      A_MIN:   bus_rdata = a_min;
      A_HOUR:  bus_rdata = a_hour;
      A_DATE:  bus_rdata = a_date;
      A_CTRL:  bus_rdata = {ae, abe, 5'b0, ft};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sec <= '0; a_min <= '0; a_hour <= '0; a_date <= '0;
      ae <= 1'b0; abe <= 1'b0; ft <= 1'b0; af <= 1'b0;
      pwr_q <= 1'b0; ft_phase <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;
      if (wr_en && bus_addr == A_SEC)  a_sec  <= bus_wdata;
      if (wr_en && bus_addr == A_MIN)  a_min  <= bus_wdata;
      if (wr_en && bus_addr == A_HOUR) a_hour <= bus_wdata;
      if (wr_en && bus_addr == A_DATE) a_date <= bus_wdata;
      if (pwr_up) begin
        ae <= 1'b0; abe <= 1'b0; ft <= 1'b0;
      end else if (wr_en && bus_addr == A_CTRL) begin
        ae <= bus_wdata[7]; abe <= bus_wdata[6]; ft <= bus_wdata[0];
      end
      if (sec_tick && hit)  af <= 1'b1;
      else if (flag_acc)    af <= 1'b0;
      if (!ft_en)           ft_phase <= 1'b0;
      else if (ft_tick)     ft_phase <= ~ft_phase;
    end
  end

  AST_AF_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && hit |=> af); // R4
  AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_acc && !wdog_irq && !ft_en |-> !irq_pull); // R7
  AST_AF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_acc && !sec_tick |=> !af); // R7
  AST_PWRUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |=> !ae && !abe && !ft); // R8
  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok && !abe && !wdog_irq && !ft_en |-> !irq_pull); // R6
  AST_NO_WRITE_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable(a_sec) && $stable(a_min) && $stable(a_hour) && $stable(a_date)); // R9
  AST_WDOG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |-> irq_pull); // R11
endmodule

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, pwr_ok = 1, osc_run = 0, sec_tick = 0, ft_tick = 0;
  logic [6:0] cur_sec = 0, cur_min = 0;
  logic [5:0] cur_hour = 0, cur_date = 0;
  logic wds = 0, wdog_zero = 0, wdog_irq = 0;
  logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_pull;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  alarm_irq_ctrl #(.AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .osc_run(osc_run),
    .sec_tick(sec_tick), .ft_tick(ft_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .wds(wds), .wdog_zero(wdog_zero),
    .wdog_irq(wdog_irq), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pull(irq_pull));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0; #1;
  endtask

  task automatic bread(input logic [3:0] a, output logic [7:0] d, output logic irq_d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata; irq_d = irq_pull;
    @(negedge clk); bus_sel = 0; bus_rd = 0; #1;
  endtask

  task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h, input logic [5:0] d);
    @(negedge clk); cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; sec_tick = 1;
    @(negedge clk); sec_tick = 0; #1;
  endtask

  task automatic ftpulse();
    @(negedge clk); ft_tick = 1;
    @(negedge clk); ft_tick = 0; #1;
  endtask

  function automatic logic exp_hit(input logic [7:0] as, input logic [7:0] am,
      input logic [7:0] ah, input logic [7:0] ad, input logic [6:0] cs,
      input logic [6:0] cm, input logic [5:0] ch, input logic [5:0] cd);
    logic s, m, h, d;
    s = (cs == as[6:0]); m = (cm == am[6:0]);
    h = (ch == ah[5:0]); d = (cd == ad[5:0]);
    case ({ad[7], ah[7], am[7], as[7]})
      4'b1110: return s;
      4'b1100: return s & m;
      4'b1000: return s & m & h;
      4'b0000: return s & m & h & d;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic listed(input logic [3:0] k);
    return k == 4'b1111 || k == 4'b1110 || k == 4'b1100 || k == 4'b1000 || k == 4'b0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic irqd, e;
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 irq after reset", irq_pull, 0);
    bread(4'h6, rd, irqd); check("R1 ctrl after reset", rd, 8'h00);
    bread(4'h0, rd, irqd); check("R1 flags after reset", rd, 8'h00);

    bwrite(4'h6, 8'h80);
    for (int i = 0; i < 48; i++) begin
      logic [7:0] as, am, ah, ad;
      logic [6:0] cs, cm;
      logic [5:0] ch, cd;
      as = 8'($urandom); am = 8'($urandom); ah = 8'($urandom); ad = 8'($urandom);
      cs = ($urandom % 2) ? as[6:0] : 7'($urandom);
      cm = ($urandom % 2) ? am[6:0] : 7'($urandom);
      ch = ($urandom % 2) ? ah[5:0] : 6'($urandom);
      cd = ($urandom % 2) ? ad[5:0] : 6'($urandom);
      bwrite(4'h2, as); bwrite(4'h3, am); bwrite(4'h4, ah); bwrite(4'h5, ad);
      tick(cs, cm, ch, cd);
      e = exp_hit(as, am, ah, ad, cs, cm, ch, cd);
      if (listed({ad[7], ah[7], am[7], as[7]})) check("R2 masked match irq", irq_pull, e);
      else check("R3 unlisted mask irq", irq_pull, e);
      bread(4'h0, rd, irqd);
      check("R4 flag bit", rd, {e, 7'b0});
      check("R7 release during flags read", irqd, 0);
      check("R7 cleared after flags read", irq_pull, 0);
    end

    bwrite(4'h2, 8'h15); bwrite(4'h3, 8'h30); bwrite(4'h4, 8'h08); bwrite(4'h5, 8'h11);
    tick(7'h15, 7'h30, 6'h08, 6'h12);
    check("R2 mask 0000 date mismatch", irq_pull, 0);
    bwrite(4'h5, 8'h91);
    tick(7'h15, 7'h30, 6'h08, 6'h12);
    check("R2 mask 1000 ignores date", irq_pull, 1);
    bread(4'h0, rd, irqd);
    @(negedge clk); cur_sec = 7'h15; cur_min = 7'h30; cur_hour = 6'h08; cur_date = 6'h11;
    bwrite(4'h5, 8'h11);
    repeat (2) @(negedge clk); #1;
    check("R4 no match without tick", irq_pull, 0);
    bread(4'h0, rd, irqd); check("R4 flag stays clear without tick", rd, 8'h00);

    bwrite(4'h2, 8'hFF); bwrite(4'h3, 8'hFF); bwrite(4'h4, 8'hFF); bwrite(4'h5, 8'hFF);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 4'h0; sec_tick = 1;
    @(negedge clk); bus_sel = 0; bus_rd = 0; sec_tick = 0; #1;
    check("R7 tick wins over clear", irq_pull, 1);
    bwrite(4'h6, 8'h00);
    check("R5 flag set but AE off", irq_pull, 0);
    bread(4'h0, rd, irqd); check("R5 flag visible with AE off", rd, 8'h80);

    bwrite(4'h6, 8'hC0);
    @(negedge clk); pwr_ok = 0;
    tick(0, 0, 0, 0);
    check("R6 backup alarm with ABE", irq_pull, 1);
    bwrite(4'h6, 8'h00); bwrite(4'h2, 8'h00);
    check("R9 ctrl write ignored in backup", irq_pull, 1);
    bread(4'h0, rd, irqd);
    check("R9 flags read no clear in backup", irq_pull, 1);
    @(negedge clk); pwr_ok = 1;
    @(negedge clk); #1;
    check("R8 AE cleared on power-up", irq_pull, 0);
    bread(4'h6, rd, irqd); check("R8 ctrl zero after power-up", rd, 8'h00);
    bread(4'h0, rd, irqd); check("R8 backup flag kept", rd, 8'h80);
    bread(4'h2, rd, irqd); check("R9 alarm reg unchanged", rd, 8'hFF);
    bwrite(4'h6, 8'h80);
    tick(0, 0, 0, 0);
    check("R5 alarm drives pin", irq_pull, 1);
    @(negedge clk); pwr_ok = 0; #1;
    check("R6 backup without ABE", irq_pull, 0);
    @(negedge clk); pwr_ok = 1;
    @(negedge clk); bread(4'h0, rd, irqd);

    bwrite(4'h3, 8'h5A); bread(4'h3, rd, irqd); check("R12 alarm readback", rd, 8'h5A);
    bwrite(4'h6, 8'hFF); bread(4'h6, rd, irqd); check("R12 ctrl layout", rd, 8'hC1);

    bwrite(4'h6, 8'h01);
    osc_run = 1; wdog_zero = 1;
    @(negedge clk); #1; check("R10 ft starts released", irq_pull, 0);
    ftpulse(); check("R10 ft first toggle", irq_pull, 1);
    ftpulse(); check("R10 ft second toggle", irq_pull, 0);
    wds = 1; wdog_zero = 0;
    ftpulse(); check("R10 ft via steering bit", irq_pull, 1);
    wds = 0;
    @(negedge clk); #1; check("R10 ft disabled releases", irq_pull, 0);
    ftpulse(); check("R10 no toggle when disabled", irq_pull, 0);
    osc_run = 0;

    @(negedge clk); wdog_irq = 1; #1;
    check("R11 watchdog drives pin", irq_pull, 1);
    @(negedge clk); wdog_irq = 0; #1;
    check("R11 watchdog released", irq_pull, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule